// File: doc/BRIEF.md
# Region-Based Bus Wait-State Controller

This controller sits on the CPU side of an on-chip memory bus. Each access carries a request, an address and a read/write flag. The controller decodes the address into a memory or peripheral region and reports that region on a code output. It then holds the CPU's ready line low for as many cycles as that region and direction need. The CPU keeps the request, address and direction steady until ready goes high, which marks the cycle in which the access completes.

The wait count is fixed for most regions. For the one-time-programmable block and for flash it comes from a small register port. Flash uses one count when the access stays inside the previously used flash page and a second count when it does not. Two of the peripheral zones can be stretched further by a peripheral ready input. One zone adds a stall between back-to-back writes. An optional protection mode delays a read that follows a write inside the peripheral zones, so that the write is known to have landed before the read.

Top module: `region_wait_ctrl`

## Requirements
- R1: The address map and region codes on `region_o` are as follows.
  - Fixed-RAM (code 1): 0x0000-0x07FF and 0x8000-0xBFFF.
  - Zone 0 (code 2): 0x0800-0x0FFF.
  - Zone 1 (code 3): 0x1000-0x17FF.
  - Zone 2 (code 4): 0x1800-0x1FFF.
  - Zone 3 (code 5): 0x2000-0x27FF.
  - OTP (code 6): 0x3000-0x3FFF.
  - Flash (code 7): 0x4000-0x7FEF.
  - Password (code 8): 0x7FF0-0x7FFF.
  - ROM (code 9): 0xE000-0xFFFF.
  - Unmapped (code 0): everything else.
- R2: RAM, zone 0 and ROM accesses complete with 0 wait states. Zones 1-3 complete writes with 0 wait states and reads with 2.
- R3: A write to zone 1 whose immediately preceding completed access was also a write to zone 1 takes 1 extra wait state.
- R4: For zones 1 and 3, an access does not complete before its wait count has elapsed, nor while `periph_rdy` is low. Zone 2 ignores `periph_rdy`.
- R5: Password accesses always take 16 wait states, whatever the registers hold.
- R6: OTP accesses take max(OTP register, 1) wait states.
- R7: A flash access is paged when address bits [15:3] equal those of the last completed flash access; paged accesses take the paged register value. Any other flash access takes max(random, paged, 1).
- R8: When protection is enabled, a read in zones 1-3 takes 1 extra wait state. This applies when the previous completed access was a write in zones 1-3 and the read address differs from that write's address. Protection is enabled after reset.
- R9: Register writes (`cfg_addr` 0 = paged, 1 = random, 2 = OTP, 3 = protection enable in bit 0) apply from the next access that begins. They never change an access already in progress.
- R10: `cpu_ready` is low outside completion and goes high exactly in the completion cycle. With N wait states, that is N cycles after the issue cycle.
- R11: An unmapped access completes with 0 wait states and raises `acc_err` for exactly its single completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until completion |
| cpu_addr | input | 16 | Access address |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_ready | output | 1 | High in the completion cycle |
| acc_err | output | 1 | Unmapped-address pulse |
| region_o | output | 4 | Decoded region code |
| periph_rdy | input | 1 | Peripheral ready for zones 1 and 3 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 4 | Register write data |

## Verification
The bench goes after the edges where the count rules meet:
- A random flash count programmed below the paged count; a design that forgot the floor would finish early.
- A zero OTP value; a design that missed the clamp would complete in 0 cycles.
- A zone-1 write pair; a design that dropped the stall would complete the second write in 0 cycles.
- A protected write-then-read with equal and with different addresses, with protection on and off; a design that got this wrong would show a cycle too many or too few.
- A register rewrite in the middle of a flash access; a design that reloaded the count from the live register would finish at the new count instead of the old one.
- Ready held low on zones 1, 2 and 3; a design that wired ready to the wrong zone would stretch zone 2 or cut zone 3 short.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [3:0] {
    RG_NONE  = 4'd0,
    RG_RAM   = 4'd1,
    RG_PF0   = 4'd2,
    RG_PF1   = 4'd3,
    RG_PF2   = 4'd4,
    RG_PF3   = 4'd5,
    RG_OTP   = 4'd6,
    RG_FLASH = 4'd7,
    RG_PWD   = 4'd8,
    RG_ROM   = 4'd9
  } region_e;

  localparam logic [1:0] CFG_PAGED = 2'd0;
  localparam logic [1:0] CFG_RAND  = 2'd1;
  localparam logic [1:0] CFG_OTP   = 2'd2;
  localparam logic [1:0] CFG_PROT  = 2'd3;
endpackage

// File: rtl/wsc_decode.sv
module wsc_decode
  import wsc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  always_comb begin
    if      (addr >= 16'h7FF0 && addr <= 16'h7FFF) region = RG_PWD;
    else if (addr <  16'h0800) region = RG_RAM;
    else if (addr <  16'h1000) region = RG_PF0;
    else if (addr <  16'h1800) region = RG_PF1;
    else if (addr <  16'h2000) region = RG_PF2;
    else if (addr <  16'h2800) region = RG_PF3;
    else if (addr <  16'h3000) region = RG_NONE;
    else if (addr <  16'h4000) region = RG_OTP;
    else if (addr <  16'h8000) region = RG_FLASH;
    else if (addr <  16'hC000) region = RG_RAM;
    else if (addr <  16'hE000) region = RG_NONE;
    else                       region = RG_ROM;
  end
endmodule

// File: rtl/wsc_cfg.sv
module wsc_cfg
  import wsc_pkg::*;
#(
  parameter int WS_W    = 4,
  parameter int RST_PG  = 2,
  parameter int RST_RND = 3,
  parameter int RST_OTP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [WS_W-1:0] wdata,
  output logic [WS_W-1:0] pg_w,
  output logic [WS_W-1:0] rnd_w,
  output logic [WS_W-1:0] otp_w,
  output logic            prot_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_w    <= WS_W'(RST_PG);
      rnd_w   <= WS_W'(RST_RND);
      otp_w   <= WS_W'(RST_OTP);
      prot_en <= 1'b1;
    end else if (we) begin
      unique case (sel)
        CFG_PAGED: pg_w    <= wdata;
        CFG_RAND:  rnd_w   <= wdata;
        CFG_OTP:   otp_w   <= wdata;
        CFG_PROT:  prot_en <= wdata[0];
      endcase
    end
  end

  // Registers change only on a write strobe (R9)
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(pg_w) && $stable(rnd_w) && $stable(otp_w) && $stable(prot_en));
endmodule

// File: rtl/wsc_seq.sv
module wsc_seq
  import wsc_pkg::*;
#(
  parameter int WS_W      = 4,
  parameter int PAGE_BITS = 3,
  parameter int RD_WAIT   = 2,
  parameter int PWD_WAIT  = 16,
  parameter int PROT_PEN  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  region_e           region,
  input  logic              periph_rdy,
  input  logic [WS_W-1:0]   pg_w,
  input  logic [WS_W-1:0]   rnd_w,
  input  logic [WS_W-1:0]   otp_w,
  input  logic              prot_en,
  output logic              ready,
  output logic              acc_err
);
  localparam int WS_MAX = (1 << WS_W) - 1;
  localparam int BASE_MAX = (PWD_WAIT > WS_MAX) ? PWD_WAIT : WS_MAX;
  localparam int CNT_W = $clog2(BASE_MAX + 2 + PROT_PEN);
  localparam int PG_W = ADDR_W - PAGE_BITS;

  function automatic logic [CNT_W-1:0] otp_eff(input logic [WS_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : CNT_W'(v);
  endfunction

  function automatic logic [CNT_W-1:0] flash_eff(input logic [WS_W-1:0] pg,
                                                 input logic [WS_W-1:0] rnd,
                                                 input logic paged_i);
    logic [WS_W-1:0] m;
    if (paged_i) return CNT_W'(pg);
    m = (rnd > pg) ? rnd : pg;
    return (m == '0) ? CNT_W'(1) : CNT_W'(m);
  endfunction

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             last_wr_pf1, last_prot_wr, fl_valid;
  logic [ADDR_W-1:0] last_addr;
  logic [PG_W-1:0]  fl_page;

  // Named internal events
  logic             start, done, is_prot, paged, stretchable, rdy_ok, cnt_zero;
  logic             b2b_stall, prot_stall;
  logic [CNT_W-1:0] base_w, load_w;

  assign is_prot     = (region == RG_PF1) || (region == RG_PF2) || (region == RG_PF3);
  assign stretchable = (region == RG_PF1) || (region == RG_PF3);
  assign paged       = fl_valid && (addr[ADDR_W-1:PAGE_BITS] == fl_page);
  assign b2b_stall   = wr && (region == RG_PF1) && last_wr_pf1;
  assign prot_stall  = prot_en && !wr && is_prot && last_prot_wr && (addr != last_addr);

  always_comb begin
    unique case (region)
      RG_PF1, RG_PF2, RG_PF3: base_w = wr ? '0 : CNT_W'(RD_WAIT);
      RG_OTP:                 base_w = otp_eff(otp_w);
      RG_FLASH:               base_w = flash_eff(pg_w, rnd_w, paged);
      RG_PWD:                 base_w = CNT_W'(PWD_WAIT);
      default:                base_w = '0;
    endcase
  end

  assign load_w   = base_w + CNT_W'(b2b_stall) + (prot_stall ? CNT_W'(PROT_PEN) : '0);
  assign start    = req && !busy;
  assign rdy_ok   = !stretchable || periph_rdy;
  assign cnt_zero = busy ? (cnt == '0) : (load_w == '0);
  assign done     = req && cnt_zero && rdy_ok;
  assign ready    = done;
  assign acc_err  = done && (region == RG_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start && !done) begin
        busy <= 1'b1;
        cnt  <= (load_w == '0) ? '0 : load_w - CNT_W'(1);
      end
    end else if (done) begin
      busy <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_wr_pf1  <= 1'b0;
      last_prot_wr <= 1'b0;
      last_addr    <= '0;
      fl_valid     <= 1'b0;
      fl_page      <= '0;
    end else if (done) begin
      last_wr_pf1  <= wr && (region == RG_PF1);
      last_prot_wr <= wr && is_prot;
      last_addr    <= addr;
      if (region == RG_FLASH) begin
        fl_valid <= 1'b1;
        fl_page  <= addr[ADDR_W-1:PAGE_BITS];
      end
    end
  end

  // Counting down keeps ready low (R10)
  p_wait_masks_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != '0) |-> !ready);
  // Zone 2 finishes when its count runs out, ready or not (R4)
  p_pf2_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt == '0) && req && (region == RG_PF2) |-> ready);
  // Password count is fixed (R5)
  p_pwd_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && (region == RG_PWD) |-> !done);
  // OTP never completes in the issue cycle (R6)
  p_otp_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && (region == RG_OTP) |-> !ready);
  // Random flash count is at least paged and at least one (R7)
  p_rand_ge_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && (region == RG_FLASH) && !paged |-> (load_w >= CNT_W'(pg_w)) && (load_w != '0));
  // Error pulse coincides with a zero-wait completion (R11)
  p_err_zero_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> ready && !busy);
endmodule

// File: rtl/region_wait_ctrl.sv
module region_wait_ctrl
  import wsc_pkg::*;
#(
  parameter int WS_W      = 4,
  parameter int PAGE_BITS = 3,
  parameter int RD_WAIT   = 2,
  parameter int PWD_WAIT  = 16,
  parameter int PROT_PEN  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  output logic              cpu_ready,
  output logic              acc_err,
  output logic [3:0]        region_o,
  input  logic              periph_rdy,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [WS_W-1:0]   cfg_wdata
);
  region_e         region;
  logic [WS_W-1:0] pg_w, rnd_w, otp_w;
  logic            prot_en;

  wsc_decode u_dec (.addr(cpu_addr), .region(region));

  wsc_cfg #(.WS_W(WS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_wdata),
    .pg_w(pg_w), .rnd_w(rnd_w), .otp_w(otp_w), .prot_en(prot_en)
  );

  wsc_seq #(
    .WS_W(WS_W), .PAGE_BITS(PAGE_BITS), .RD_WAIT(RD_WAIT),
    .PWD_WAIT(PWD_WAIT), .PROT_PEN(PROT_PEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(cpu_req), .addr(cpu_addr), .wr(cpu_wr),
    .region(region), .periph_rdy(periph_rdy), .pg_w(pg_w), .rnd_w(rnd_w),
    .otp_w(otp_w), .prot_en(prot_en), .ready(cpu_ready), .acc_err(acc_err)
  );

  assign region_o = region;
endmodule

// File: tb/region_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module region_wait_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_wr = 1'b0, periph_rdy = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [3:0]  cfg_wdata = '0;
  logic        cpu_ready, acc_err;
  logic [3:0]  region_o;

  int checks = 0, failures = 0;
  int m_pg = 2, m_rnd = 3, m_otp = 3, m_prot = 1;
  int l_wr_pf1 = 0, l_prot_wr = 0, l_addr = 0, f_valid = 0, f_page = 0;

  always #2 clk = ~clk;

  region_wait_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_ready(cpu_ready), .acc_err(acc_err), .region_o(region_o), .periph_rdy(periph_rdy),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int brg(int a);
    if (a >= 'h7FF0 && a <= 'h7FFF) return 8;
    if (a < 'h0800) return 1;
    if (a < 'h1000) return 2;
    if (a < 'h1800) return 3;
    if (a < 'h2000) return 4;
    if (a < 'h2800) return 5;
    if (a < 'h3000) return 0;
    if (a < 'h4000) return 6;
    if (a < 'h8000) return 7;
    if (a < 'hC000) return 1;
    if (a < 'hE000) return 0;
    return 9;
  endfunction

  function automatic int expect_wait(int a, int w);
    int r = brg(a), e = 0, m;
    case (r)
      3, 4, 5: e = w ? 0 : 2;
      6: e = (m_otp < 1) ? 1 : m_otp;
      7: begin
        if (f_valid && (a >> 3) == f_page) e = m_pg;
        else begin m = (m_rnd > m_pg) ? m_rnd : m_pg; e = (m < 1) ? 1 : m; end
      end
      8: e = 16;
      default: e = 0;
    endcase
    if (w && r == 3 && l_wr_pf1) e += 1;
    if (m_prot && !w && r >= 3 && r <= 5 && l_prot_wr && a != l_addr) e += 1;
    return e;
  endfunction

  task automatic cfg_write(int sel, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = sel[1:0]; cfg_wdata = val[3:0];
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel) 0: m_pg = val; 1: m_rnd = val; 2: m_otp = val; default: m_prot = val & 1; endcase
  endtask

  task automatic access(string tag, int a, int w, int rdy_delay = 0,
                        int cfg_at = -1, int cfg_sel = 0, int cfg_val = 0);
    int r = brg(a), e, exp_done, cyc = 0, got = -1, err_seen = 0, rg_seen = 0;
    e = expect_wait(a, w);
    exp_done = ((r == 3 || r == 5) && rdy_delay > e) ? rdy_delay : e;
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a[15:0]; cpu_wr = w[0]; periph_rdy = (rdy_delay == 0);
    while (got < 0 && cyc < 100) begin
      if (cyc == cfg_at) begin cfg_we = 1'b1; cfg_addr = cfg_sel[1:0]; cfg_wdata = cfg_val[3:0]; end
      else cfg_we = 1'b0;
      #1;
      if (cpu_ready) begin got = cyc; err_seen = acc_err; rg_seen = region_o; end
      @(negedge clk);
      cyc++;
      periph_rdy = (cyc >= rdy_delay);
    end
    cpu_req = 1'b0; cfg_we = 1'b0; periph_rdy = 1'b1;
    check(tag, got, exp_done);
    check({tag, " R1 region"}, rg_seen, r);
    check({tag, " R11 err"}, err_seen, (r == 0) ? 1 : 0);
    if (cfg_at >= 0 && cfg_at <= got)
      case (cfg_sel) 0: m_pg = cfg_val; 1: m_rnd = cfg_val; 2: m_otp = cfg_val; default: m_prot = cfg_val & 1; endcase
    l_wr_pf1 = (w && r == 3); l_prot_wr = (w && r >= 3 && r <= 5); l_addr = a;
    if (r == 7) begin f_valid = 1; f_page = a >> 3; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int addrs[12] = '{'h0010, 'h0900, 'h1004, 'h1808, 'h2010, 'h2900,
                      'h3100, 'h4100, 'h7FF3, 'h9000, 'hD000, 'hF000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 reset ready low", cpu_ready, 0);
    check("R11 reset err low", acc_err, 0);

    // R8 protection is on after reset
    access("R8 prot wr", 'h1000, 1);
    access("R8 prot rd diff addr", 'h2004, 0);
    access("R8 prot wr2", 'h1010, 1);
    access("R8 prot rd same addr", 'h1010, 0);
    cfg_write(3, 0);
    access("R8 off wr", 'h1000, 1);
    access("R8 off rd", 'h2004, 0);
    cfg_write(3, 1);

    // R2 sweep over regions and directions
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 12; i++)
        for (int w = 0; w < 2; w++)
          access("R2 sweep", addrs[i] + p, w);

    // R3 back-to-back zone-1 writes
    access("R3 first wr", 'h1100, 1);
    access("R3 second wr", 'h1102, 1);
    access("R3 other zone wr", 'h1900, 1);
    access("R3 after break", 'h1104, 1);

    // R4 ready stretch
    for (int d = 0; d < 5; d++) begin
      access("R4 pf1 rd", 'h1200, 0, d);
      access("R4 pf3 wr", 'h2200, 1, d);
      access("R4 pf2 rd", 'h1A00, 0, d);
      access("R4 pf2 wr", 'h1A00, 1, d);
    end

    // R6 OTP floor, R5 password fixed
    for (int v = 0; v < 4; v++) begin
      cfg_write(2, v);
      access("R6 otp", 'h3200 + v, 0);
      access("R5 password", 'h7FF0 + v, v & 1);
    end

    // R7 flash paged / random
    for (int pg = 0; pg < 4; pg++)
      for (int rn = 0; rn < 5; rn++) begin
        cfg_write(0, pg);
        cfg_write(1, rn);
        access("R7 random", 'h4100 + pg * 64 + rn, 0);
        access("R7 paged", 'h4100 + pg * 64 + (rn ^ 1), 1);
        access("R7 new page", 'h6000 + rn * 8, 0);
      end

    // R9 mid-access register write uses old count
    cfg_write(0, 0);
    cfg_write(1, 6);
    access("R9 old count kept", 'h5000, 0, 0, 2, 1, 1);
    access("R9 new count used", 'h5800, 0);

    // R11 unmapped
    access("R11 unmapped", 'h2A00, 0);
    @(negedge clk); #1;
    check("R11 pulse single cycle", acc_err, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule